// File: doc/BRIEF.md
# SHA-1 Word-Bus Register Wrapper

This block places a SHA-1 compression engine behind a 32-bit word-wide register port. A host writes a 512-bit message block as sixteen words into staging registers, then writes a control word to start either a fresh hash or a continuation of the running chain. When the engine finishes, the wrapper copies the 160-bit result into its own digest registers, and the host reads it back as five words.

The engine takes its copy of the block only when a start is accepted. After that, the staging registers belong to the host again. The host can therefore load block N+1 while block N is still going through its 80 rounds, and can then issue the continuation as soon as the status word shows the engine is ready. Message padding is the host's job.

Top module: `hash_mmio`

## Requirements
- R1: After reset, the status word (address 0x01) reads 0x0000_0001: bit 0 ready = 1 and bit 1 digest-valid = 0. Every digest word and every block word reads zero.
- R2: Block word i (0..15) is read/write at address 0x10+i. A read returns the last value written. Word 0 supplies the most significant 32 bits of the 512-bit block.
- R3: Writing 0x1 to the control word (address 0x00, bit 0 = fresh start) hashes the staged block from the standard SHA-1 initial value. The digest is then readable at 0x20..0x24, with word 0x20 holding the most significant 32 bits.
- R4: Writing 0x2 to the control word (bit 1 = continue) hashes the staged block from the previously produced digest. This lets multi-block messages be chained.
- R5: Block-word writes made after a start has been accepted do not affect that computation. The host may stage the next block while the engine is busy.
- R6: Control bits are single-cycle pulses. The control word reads as zero. Status bit 0 reads 0 while a computation is running. If both bits are written together, the fresh start wins.
- R7: Status bit 1 clears when a start is accepted and sets when a new digest is captured. Until then, the digest words keep returning the last completed digest.
- R8: Reads of unmapped addresses return zero. Writes to the status word or to the digest words change nothing.
- R9: A start written while the engine is busy is dropped and does not disturb the running computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access select |
| we | input | 1 | 1 = write, 0 = read (when cs = 1) |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after the read address |

## Verification
Read data is registered at the edge that samples the address, so the bench compares it at the following falling edge. A scoreboard queue pairs each expected word with that edge. A control write at edge E0 produces the start pulse at E1. The engine loads the block at E1, runs rounds from E2 to E81, folds the result into the chain at E82, and the wrapper captures the digest at E83. The bench therefore never reads a digest at a fixed cycle. It polls status bit 1 and reads the digest only after that bit is seen set. Busy-state checks are timed to land a few cycles after the start, so they fall well inside the 80-round window.

// File: rtl/hash_mmio_pkg.sv
package hash_mmio_pkg;

    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 16;
    localparam int DIG_WORDS = 5;
    localparam int ROUNDS    = 80;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int DIG_W     = WORD_W * DIG_WORDS;

    typedef logic [WORD_W-1:0] word_t;

    localparam word_t CHAIN_IV [DIG_WORDS] = '{
        32'h6745_2301, 32'hEFCD_AB89, 32'h98BA_DCFE, 32'h1032_5476, 32'hC3D2_E1F0
    };

    function automatic word_t rotl(input word_t x, input int unsigned n);
        word_t r;
        r = (x << n) | (x >> (WORD_W - n));
        return r;
    endfunction

    function automatic word_t mix_f(input int unsigned t, input word_t b, input word_t c, input word_t d);
        word_t r;
        if (t < 20)      r = (b & c) | (~b & d);
        else if (t < 40) r = b ^ c ^ d;
        else if (t < 60) r = (b & c) | (b & d) | (c & d);
        else             r = b ^ c ^ d;
        return r;
    endfunction

    function automatic word_t mix_k(input int unsigned t);
        word_t r;
        if (t < 20)      r = 32'h5A82_7999;
        else if (t < 40) r = 32'h6ED9_EBA1;
        else if (t < 60) r = 32'h8F1B_BCDC;
        else             r = 32'hCA62_C1D6;
        return r;
    endfunction

endpackage

// File: rtl/hash_wsched.sv
module hash_wsched
    import hash_mmio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [BLK_W-1:0] blk_i,
    output word_t            w_o
);
    typedef struct packed {
        logic [BLK_WORDS-1:0][WORD_W-1:0] win;
    } win_t;

    win_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load_i) begin
            for (int i = 0; i < BLK_WORDS; i++) begin
                w_d.win[i] = blk_i[(BLK_WORDS-1-i)*WORD_W +: WORD_W];
            end
        end else if (shift_i) begin
            for (int i = 0; i < BLK_WORDS-1; i++) begin
                w_d.win[i] = w_q.win[i+1];
            end
            w_d.win[BLK_WORDS-1] = rotl(w_q.win[13] ^ w_q.win[8] ^ w_q.win[2] ^ w_q.win[0], 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign w_o = w_q.win[0];

endmodule

// File: rtl/hash_rounds.sv
module hash_rounds
    import hash_mmio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             next_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             ready_o,
    output logic             dvalid_o,
    output logic [DIG_W-1:0] digest_o
);
    localparam int TW = $clog2(ROUNDS);
    localparam logic [TW-1:0] T_LAST = TW'(ROUNDS - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_t;

    typedef struct packed {
        state_t                           st;
        logic [TW-1:0]                    t;
        logic [DIG_WORDS-1:0][WORD_W-1:0] h;
        logic [DIG_WORDS-1:0][WORD_W-1:0] v;
        logic                             done;
    } core_t;

    core_t c_d, c_q;
    logic  accept;
    word_t w_cur;
    word_t tmp;
    word_t base;

    hash_wsched i_wsched (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .shift_i (c_q.st == ST_RUN),
        .blk_i   (blk_i),
        .w_o     (w_cur)
    );

    always_comb begin
        c_d    = c_q;
        accept = (c_q.st == ST_IDLE) && (init_i || next_i);
        tmp    = rotl(c_q.v[0], 5) + mix_f(int'(c_q.t), c_q.v[1], c_q.v[2], c_q.v[3])
               + c_q.v[4] + mix_k(int'(c_q.t)) + w_cur;
        base   = '0;
        case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    for (int i = 0; i < DIG_WORDS; i++) begin
                        base      = init_i ? CHAIN_IV[i] : c_q.h[i];
                        c_d.h[i]  = base;
                        c_d.v[i]  = base;
                    end
                    c_d.t    = '0;
                    c_d.st   = ST_RUN;
                    c_d.done = 1'b0;
                end
            end
            ST_RUN: begin
                c_d.v[0] = tmp;
                c_d.v[1] = c_q.v[0];
                c_d.v[2] = rotl(c_q.v[1], 30);
                c_d.v[3] = c_q.v[2];
                c_d.v[4] = c_q.v[3];
                c_d.t    = c_q.t + 1'b1;
                if (c_q.t == T_LAST) c_d.st = ST_FIN;
            end
            ST_FIN: begin
                for (int i = 0; i < DIG_WORDS; i++) begin
                    c_d.h[i] = c_q.h[i] + c_q.v[i];
                end
                c_d.done = 1'b1;
                c_d.st   = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ready_o  = (c_q.st == ST_IDLE);
    assign dvalid_o = c_q.done;

    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_dig
        assign digest_o[(DIG_WORDS-1-g)*WORD_W +: WORD_W] = c_q.h[g];
    end

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && (init_i || next_i)) |=> !ready_o) else $error("start did not leave ready"); // R6
    AST_HASH_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !dvalid_o) |=> (ready_o || $stable(digest_o))) else $error("chain moved mid-run"); // R7
    AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && (init_i || next_i)) |=> !(ready_o && dvalid_o && $stable(digest_o))) else $error("start accepted while busy"); // R9

endmodule

// File: rtl/hash_mmio.sv
module hash_mmio
    import hash_mmio_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CTRL_ADR = 'h00,
    parameter int STAT_ADR = 'h01,
    parameter int BLK_BASE = 'h10,
    parameter int DIG_BASE = 'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int BIDX_W = $clog2(BLK_WORDS);
    localparam int DIDX_W = $clog2(DIG_WORDS);

    typedef struct packed {
        logic [BLK_WORDS-1:0][WORD_W-1:0] blk;
        logic [DIG_WORDS-1:0][WORD_W-1:0] dig;
        logic                             go_init;
        logic                             go_next;
        logic                             dv;
        logic                             vprev;
        logic [WORD_W-1:0]                rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic              core_ready, core_dvalid;
    logic [DIG_W-1:0]  core_digest;
    logic [BLK_W-1:0]  blk_flat;
    logic [DIG_W-1:0]  dig_flat;
    logic              wr, rd, in_blk, in_dig, mapped, cap;
    logic [ADDR_W-1:0] boff, doff;
    logic [BIDX_W-1:0] bidx;
    logic [DIDX_W-1:0] didx;

    for (genvar g = 0; g < BLK_WORDS; g++) begin : g_blk
        assign blk_flat[(BLK_WORDS-1-g)*WORD_W +: WORD_W] = r_q.blk[g];
    end
    for (genvar g = 0; g < DIG_WORDS; g++) begin : g_dig
        assign dig_flat[(DIG_WORDS-1-g)*WORD_W +: WORD_W] = r_q.dig[g];
    end

    hash_rounds i_rounds (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (r_q.go_init),
        .next_i   (r_q.go_next),
        .blk_i    (blk_flat),
        .ready_o  (core_ready),
        .dvalid_o (core_dvalid),
        .digest_o (core_digest)
    );

    always_comb begin
        r_d         = r_q;
        r_d.go_init = 1'b0;
        r_d.go_next = 1'b0;
        wr     = cs && we;
        rd     = cs && !we;
        boff   = addr - ADDR_W'(BLK_BASE);
        doff   = addr - ADDR_W'(DIG_BASE);
        bidx   = boff[BIDX_W-1:0];
        didx   = doff[DIDX_W-1:0];
        in_blk = (addr >= ADDR_W'(BLK_BASE)) && (addr < ADDR_W'(BLK_BASE + BLK_WORDS));
        in_dig = (addr >= ADDR_W'(DIG_BASE)) && (addr < ADDR_W'(DIG_BASE + DIG_WORDS));
        mapped = in_blk || in_dig || (addr == ADDR_W'(STAT_ADR));

        if (wr && addr == ADDR_W'(CTRL_ADR)) begin
            r_d.go_init = wdata[0];
            r_d.go_next = wdata[1] && !wdata[0];
        end
        if (wr && in_blk) r_d.blk[bidx] = wdata;

        r_d.vprev = core_dvalid;
        cap       = core_dvalid && !r_q.vprev;
        if (cap) begin
            for (int i = 0; i < DIG_WORDS; i++) begin
                r_d.dig[i] = core_digest[(DIG_WORDS-1-i)*WORD_W +: WORD_W];
            end
            r_d.dv = 1'b1;
        end
        if ((r_q.go_init || r_q.go_next) && core_ready) r_d.dv = 1'b0;

        if (rd) begin
            r_d.rdata = '0;
            if (addr == ADDR_W'(STAT_ADR)) r_d.rdata = {30'd0, r_q.dv, core_ready};
            else if (in_blk)               r_d.rdata = r_q.blk[bidx];
            else if (in_dig)               r_d.rdata = r_q.dig[didx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rdata = r_q.rdata;

    AST_PULSE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.go_init || r_q.go_next) |-> $past(cs && we && addr == ADDR_W'(CTRL_ADR))) else $error("stray start"); // R6
    AST_ONE_START_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.go_init, r_q.go_next})) else $error("both starts"); // R6
    AST_CAPTURE_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_dvalid) |=> (dig_flat == $past(core_digest))) else $error("digest not captured"); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !mapped) |=> (rdata == '0)) else $error("unmapped read nonzero"); // R8
    AST_BLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && in_blk) |=> (r_q.blk[$past(bidx)] == $past(wdata))) else $error("block write lost"); // R2

endmodule

// File: tb/test_hash_mmio.sv
module test_hash_mmio;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tb_chk = 1'b0;
    logic        mon_due = 1'b0;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t sbq[$];

    localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h01, A_BLK = 8'h10, A_DIG = 8'h20;

    hash_mmio i_hash_mmio (.clk(clk), .rst_n(rst_n), .cs(cs), .we(we),
                           .addr(addr), .wdata(wdata), .rdata(rdata));

    always #5 clk = ~clk;

    always @(posedge clk) mon_due <= cs && !we && tb_chk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (mon_due) begin
            if (sbq.size() == 0) check(1'b0, "scoreboard underflow", rdata, 32'h0);
            else begin
                exp_t e;
                e = sbq.pop_front();
                check(rdata === e.exp, e.tag, rdata, e.exp);
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); cs = 1'b1; we = 1'b1; addr = a; wdata = d; tb_chk = 1'b0;
        @(negedge clk); cs = 1'b0; we = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_t x;
        x.exp = e; x.tag = tag;
        sbq.push_back(x);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a; tb_chk = 1'b1;
        @(negedge clk); cs = 1'b0; tb_chk = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); cs = 1'b1; we = 1'b0; addr = a; tb_chk = 1'b0;
        @(negedge clk); v = rdata; cs = 1'b0;
    endtask

    task automatic wait_valid(input string tag);
        logic [31:0] s;
        bit seen;
        seen = 1'b0;
        for (int k = 0; k < 200; k++) begin
            peek(A_STAT, s);
            if (s[1]) begin seen = 1'b1; break; end
        end
        check(seen, tag, s, 32'h3);
    endtask

    task automatic load_blk(input logic [15:0][31:0] b);
        for (int i = 0; i < 16; i++) bus_wr(A_BLK + 8'(i), b[i]);
    endtask

    task automatic expect_dig(input logic [4:0][31:0] d, input string tag);
        for (int i = 0; i < 5; i++) expect_rd(A_DIG + 8'(i), d[i], tag);
    endtask

    initial begin
        logic [15:0][31:0] b_abc, b_m1, b_m2, b_junk;
        logic [4:0][31:0]  d_abc, d_two;
        b_abc = '0; b_abc[0] = 32'h6162_6380; b_abc[15] = 32'h0000_0018;
        b_m1 = '0;
        b_m1[0]=32'h61626364; b_m1[1]=32'h62636465; b_m1[2]=32'h63646566; b_m1[3]=32'h64656667;
        b_m1[4]=32'h65666768; b_m1[5]=32'h66676869; b_m1[6]=32'h6768696a; b_m1[7]=32'h68696a6b;
        b_m1[8]=32'h696a6b6c; b_m1[9]=32'h6a6b6c6d; b_m1[10]=32'h6b6c6d6e; b_m1[11]=32'h6c6d6e6f;
        b_m1[12]=32'h6d6e6f70; b_m1[13]=32'h6e6f7071; b_m1[14]=32'h80000000;
        b_m2 = '0; b_m2[15] = 32'h0000_01c0;
        for (int i = 0; i < 16; i++) b_junk[i] = 32'hDEAD_0000 + 32'(i * 32'h1111);
        d_abc[0]=32'ha9993e36; d_abc[1]=32'h4706816a; d_abc[2]=32'hba3e2571; d_abc[3]=32'h7850c26c; d_abc[4]=32'h9cd0d89d;
        d_two[0]=32'h84983e44; d_two[1]=32'h1c3bd26e; d_two[2]=32'hbaae4aa1; d_two[3]=32'hf95129e5; d_two[4]=32'he54670f1;

        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        expect_rd(A_STAT, 32'h1, "R1 status after reset");
        expect_dig('0, "R1 digest zero after reset");
        expect_rd(A_BLK + 8'd7, 32'h0, "R1 block zero after reset");

        load_blk(b_junk);
        for (int i = 0; i < 16; i++) expect_rd(A_BLK + 8'(i), b_junk[i], "R2 block readback");

        bus_wr(A_DIG, 32'hFFFF_FFFF);
        bus_wr(A_STAT, 32'hFFFF_FFFF);
        expect_rd(A_DIG, 32'h0, "R8 digest write ignored");
        expect_rd(A_STAT, 32'h1, "R8 status write ignored");
        expect_rd(A_CTRL, 32'h0, "R6 control reads zero");
        expect_rd(8'h05, 32'h0, "R8 unmapped 0x05");
        expect_rd(8'h25, 32'h0, "R8 unmapped 0x25");
        expect_rd(8'hFF, 32'h0, "R8 unmapped 0xFF");

        load_blk(b_abc);
        bus_wr(A_CTRL, 32'h1);
        expect_rd(A_STAT, 32'h0, "R6 busy after start");
        load_blk(b_junk);
        wait_valid("R3 digest valid");
        expect_dig(d_abc, "R3 R5 single block digest");
        expect_rd(A_STAT, 32'h3, "R7 ready and valid");

        load_blk(b_m1);
        bus_wr(A_CTRL, 32'h3);
        expect_rd(A_STAT, 32'h0, "R7 valid cleared on start");
        expect_rd(A_DIG, d_abc[0], "R7 old digest held while busy");
        load_blk(b_m2);
        bus_wr(A_CTRL, 32'h2);
        wait_valid("R9 first block done");
        bus_wr(A_CTRL, 32'h2);
        wait_valid("R4 second block done");
        expect_dig(d_two, "R4 R5 R9 chained digest");
        expect_rd(A_STAT, 32'h3, "R4 status after chain");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "scoreboard drained", 32'(sbq.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule